// File: doc/BRIEF.md
# Polled I2C Byte-Stream Target

This block is an I2C target that hands a stream of bytes to an external master which keeps polling it. A local producer pushes bytes into a small transmit FIFO. The master reads that FIFO by addressing the block with the R/W bit set. When the FIFO runs dry, the block does not refuse the read. It keeps answering with the filler byte 0xFF, so the master can poll without any handshake and discard the filler bytes.

The master generates every SCL edge, so the block has no rate setting and never stretches the clock. Both bus lines are synchronized and glitch-filtered before START, STOP and clock edges are detected. SDA is only ever pulled low. Bytes that the master writes to the block are presented on a one-cycle strobe. A poll watchdog counts system clocks since the last address-matched read. If polling stops for 1.5 s, producer writes are refused until polling resumes. Bytes already queued when this happens stay in the FIFO.

Top module: `i2c_stream_target`

## Requirements
- R1: After reset, SDA is released (`sda_pull`=0), the address is 0x42, `poll_stalled` is 0 and `prod_ready` is 1.
- R2: The first byte after a START or repeated START is the address in bits 7:1 and R/W in bit 0 (1 = read). The block ACKs it, by pulling SDA low in the ninth clock, only when bits 7:1 equal its address. At the default address, 0x84 (write) and 0x85 (read) are ACKed. Any other address byte gets no ACK, and the block leaves SDA alone until the next START or STOP.
- R3: A cycle with `cfg_addr_we`=1 replaces the 7-bit address with `cfg_addr`. After that, the old address is no longer ACKed.
- R4: On a read, queued bytes are shifted out MSB first in the order they were produced. Each master ACK fetches the next byte.
- R5: Every byte read while the FIFO is empty is 0xFF.
- R6: On a write, each data byte is ACKed and appears on `rx_data` with a single-cycle `rx_valid` pulse.
- R7: After a master NACK on a read byte, the block releases SDA. It removes no further byte from the FIFO until a new address-matched read.
- R8: A repeated START in the middle of a transfer restarts the address phase, and the new direction takes effect.
- R9: If no address-matched read occurs for TIMEOUT system clocks (1.5 s of `CLK_HZ`), `poll_stalled` rises and producer writes are refused. The next address-matched read clears it.
- R10: Bytes queued before the watchdog fires are still delivered by the next read.
- R11: SDA is only pulled low, and the pull only begins while the filtered SCL is low.
- R12: `prod_ready` is 0 while the FIFO holds DEPTH bytes, and a byte offered then is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL line as seen at the pad |
| sda_in | input | 1 | SDA line as seen at the pad |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release |
| cfg_addr_we | input | 1 | Load a new target address |
| cfg_addr | input | 7 | New 7-bit target address |
| prod_valid | input | 1 | Producer offers a byte |
| prod_data | input | 8 | Producer byte |
| prod_ready | output | 1 | Producer byte is accepted this cycle |
| rx_valid | output | 1 | Single-cycle strobe for a byte written by the master |
| rx_data | output | 8 | Byte written by the master |
| poll_stalled | output | 1 | Poll watchdog has expired |

## Verification
A bus event reaches the protocol logic about six system clocks after the pad changes: two synchronizer flops, the filter window and the edge register. `sda_pull` therefore settles well within the quarter bit (10 clocks) that the bench master waits before it raises SCL, and the bench samples SDA only at the middle of the SCL-high phase. `rx_valid` is due a few cycles after the eighth falling SCL edge. The monitor that watches it compares against a queue, so it does not depend on the exact cycle. `poll_stalled` is checked with a margin of several hundred cycles on each side of the TIMEOUT window.

// File: rtl/i2c_stream_pkg.sv
package i2c_stream_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK_A, ST_TX, ST_TX_ACK, ST_RX, ST_ACK_W, ST_WAIT
  } bus_state_e;
  localparam logic [7:0] FILL_BYTE  = 8'hFF;
  localparam logic [6:0] RESET_ADDR = 7'h42;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int LINES = 2,
  parameter int FILT  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] clean
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [1:0]      sync_q;
    logic [FILT-1:0] hist_q;
    logic            out_q, out_n;

    always_comb begin
      out_n = out_q;
      if (&hist_q)       out_n = 1'b1;
      else if (~|hist_q) out_n = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '1;
        hist_q <= '1;
        out_q  <= 1'b1;
      end else begin
        sync_q <= {sync_q[0], raw[g]};
        hist_q <= {hist_q[FILT-2:0], sync_q[1]};
        out_q  <= out_n;
      end
    end
    assign clean[g] = out_q;
  end
endmodule

// File: rtl/i2c_tx_fifo.sv
module i2c_tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  logic [AW:0]  wp_q, rp_q;
  logic [W-1:0] mem_q [DEPTH];

  assign empty   = (wp_q == rp_q);
  assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign rd_data = mem_q[rp_q[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (wr_en) wp_q <= wp_q + 1'b1;
      if (rd_en) rp_q <= rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wp_q[AW-1:0]] <= wr_data;
  end

  // R12
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> !full);
  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> !empty);
endmodule

// File: rtl/i2c_poll_watchdog.sv
module i2c_poll_watchdog #(
  parameter int TIMEOUT = 300_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic stalled
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);
  logic [CW-1:0] cnt_q, cnt_n;
  logic          stl_q, stl_n;

  always_comb begin
    cnt_n = cnt_q;
    stl_n = stl_q;
    if (kick) begin
      cnt_n = '0;
      stl_n = 1'b0;
    end else if (!stl_q) begin
      if (cnt_q == LAST) stl_n = 1'b1;
      else               cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      stl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      stl_q <= stl_n;
    end
  end
  assign stalled = stl_q;

  // R9
  stall_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(stl_q) |-> $past(kick));
  // R9
  stall_set_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(stl_q) |-> !$past(kick));
endmodule

// File: rtl/i2c_stream_target.sv
module i2c_stream_target
  import i2c_stream_pkg::*;
#(
  parameter int CLK_HZ = 200_000_000,
  parameter int DEPTH  = 8,
  parameter int FILT   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  input  logic       cfg_addr_we,
  input  logic [6:0] cfg_addr,
  input  logic       prod_valid,
  input  logic [7:0] prod_data,
  output logic       prod_ready,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       poll_stalled
);
  localparam int TIMEOUT = (CLK_HZ / 2) * 3;

  logic [1:0] clean;
  logic       scl_f, sda_f, scl_d, sda_d;
  logic       scl_rise, scl_fall, bus_start, bus_stop;

  i2c_line_filter #(.LINES(2), .FILT(FILT)) u_filt (
    .clk(clk), .rst_n(rst_n), .raw({scl_in, sda_in}), .clean(clean));
  assign scl_f = clean[1];
  assign sda_f = clean[0];

  assign scl_rise  = scl_f & ~scl_d;
  assign scl_fall  = ~scl_f & scl_d;
  assign bus_start = scl_f & scl_d & sda_d & ~sda_f;
  assign bus_stop  = scl_f & scl_d & ~sda_d & sda_f;

  logic       fifo_wr, fifo_rd, fifo_full, fifo_empty;
  logic [7:0] fifo_q, tx_byte;
  logic       kick;

  assign prod_ready = ~fifo_full & ~poll_stalled;
  assign fifo_wr    = prod_valid & prod_ready;
  assign tx_byte    = fifo_empty ? FILL_BYTE : fifo_q;

  i2c_tx_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(fifo_wr), .wr_data(prod_data),
    .rd_en(fifo_rd), .rd_data(fifo_q), .full(fifo_full), .empty(fifo_empty));

  i2c_poll_watchdog #(.TIMEOUT(TIMEOUT)) u_wd (
    .clk(clk), .rst_n(rst_n), .kick(kick), .stalled(poll_stalled));

  bus_state_e st_q, st_n;
  logic [3:0] cnt_q, cnt_n;
  logic [7:0] sh_q, sh_n, rxd_n;
  logic       oe_q, oe_n, rw_q, rw_n, mack_q, mack_n, rxv_n;
  logic [6:0] addr_q;

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    oe_n    = oe_q;
    rw_n    = rw_q;
    mack_n  = mack_q;
    rxv_n   = 1'b0;
    rxd_n   = rx_data;
    fifo_rd = 1'b0;
    kick    = 1'b0;
    if (bus_start) begin
      st_n  = ST_ADDR;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (bus_stop) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_n  = {sh_q[6:0], sda_f};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (sh_q[7:1] == addr_q) begin
              st_n = ST_ACK_A;
              oe_n = 1'b1;
              rw_n = sh_q[0];
              kick = sh_q[0];
            end else begin
              st_n = ST_WAIT;
            end
          end
        end
        ST_ACK_A, ST_TX_ACK: begin
          if (scl_rise && st_q == ST_TX_ACK) begin
            mack_n = ~sda_f;
          end else if (scl_fall) begin
            cnt_n = '0;
            if (st_q == ST_ACK_A && !rw_q) begin
              oe_n = 1'b0;
              st_n = ST_RX;
            end else if (st_q == ST_ACK_A || mack_q) begin
              fifo_rd = ~fifo_empty;
              sh_n    = tx_byte;
              oe_n    = ~tx_byte[7];
              st_n    = ST_TX;
            end else begin
              oe_n = 1'b0;
              st_n = ST_WAIT;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              oe_n = 1'b0;
              st_n = ST_TX_ACK;
            end else begin
              sh_n  = {sh_q[6:0], 1'b0};
              oe_n  = ~sh_q[6];
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        ST_RX: begin
          if (scl_rise) begin
            sh_n  = {sh_q[6:0], sda_f};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            rxv_n = 1'b1;
            rxd_n = sh_q;
            oe_n  = 1'b1;
            st_n  = ST_ACK_W;
          end
        end
        ST_ACK_W: begin
          if (scl_fall) begin
            oe_n  = 1'b0;
            cnt_n = '0;
            st_n  = ST_RX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      oe_q     <= 1'b0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
      addr_q   <= RESET_ADDR;
    end else begin
      st_q     <= st_n;
      cnt_q    <= cnt_n;
      sh_q     <= sh_n;
      oe_q     <= oe_n;
      rw_q     <= rw_n;
      mack_q   <= mack_n;
      rx_valid <= rxv_n;
      rx_data  <= rxd_n;
      scl_d    <= scl_f;
      sda_d    <= sda_f;
      if (cfg_addr_we) addr_q <= cfg_addr;
    end
  end
  assign sda_pull = oe_q;

  // R11
  sda_pull_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_pull) |-> !scl_f);
  // R6
  rx_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid);
  // R7
  no_pop_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT || st_q == ST_IDLE) |-> !fifo_rd);
endmodule

// File: tb/i2c_stream_target_test.sv
module i2c_stream_target_test;
  localparam int Q       = 10;
  localparam int CLK_HZ  = 20000;
  localparam int TIMEOUT = (CLK_HZ / 2) * 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_pull, cfg_addr_we = 1'b0, prod_valid = 1'b0, prod_ready;
  logic rx_valid, poll_stalled;
  logic [6:0] cfg_addr = '0;
  logic [7:0] prod_data = '0, rx_data;
  logic sda_line;

  always #2.5 clk = ~clk;
  assign sda_line = m_sda & ~sda_pull;

  i2c_stream_target #(.CLK_HZ(CLK_HZ), .DEPTH(8), .FILT(3)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line), .sda_pull(sda_pull),
    .cfg_addr_we(cfg_addr_we), .cfg_addr(cfg_addr), .prod_valid(prod_valid),
    .prod_data(prod_data), .prod_ready(prod_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .poll_stalled(poll_stalled));

  int errs = 0, checks = 0;
  logic [7:0] exp_rd[$], exp_rx[$];
  string tag_rd[$];
  logic [7:0] got;
  event rd_ev;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitors
  initial forever begin
    @(rd_ev);
    if (exp_rd.size() == 0) chk("R4 unexpected read", got, 999);
    else chk(tag_rd.pop_front(), got, exp_rd.pop_front());
  end
  always @(negedge clk) begin
    if (rx_valid) begin
      if (exp_rx.size() == 0) chk("R6 unexpected rx", rx_data, 999);
      else chk("R6 rx byte", rx_data, exp_rx.pop_front());
    end
  end

  task automatic wq(input int n); repeat (n * Q) @(negedge clk); endtask
  task automatic bstart(); m_sda = 1; wq(1); m_scl = 1; wq(1); m_sda = 0; wq(1); m_scl = 0; wq(1); endtask
  task automatic bstop();  m_sda = 0; wq(1); m_scl = 1; wq(1); m_sda = 1; wq(1); endtask
  task automatic wbit(input logic b); m_sda = b; wq(1); m_scl = 1; wq(2); m_scl = 0; wq(1); endtask
  task automatic rbit(output logic b); m_sda = 1; wq(1); m_scl = 1; wq(1); b = sda_line; wq(1); m_scl = 0; wq(1); endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(input logic last);
    logic [7:0] d;
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    wbit(last);
    got = d;
    ->rd_ev;
  endtask

  task automatic expect_rd(input logic [7:0] v, input string tag);
    exp_rd.push_back(v); tag_rd.push_back(tag);
  endtask

  task automatic produce(input logic [7:0] d, input string tag);
    @(negedge clk);
    prod_valid = 1; prod_data = d;
    if (prod_ready) expect_rd(d, tag);
    @(negedge clk);
    prod_valid = 0;
  endtask

  task automatic read_n(input logic [6:0] a, input int n, input string tag);
    logic ack;
    bstart();
    send_byte({a, 1'b1}, ack);
    chk({tag, " read addr ack"}, ack, 1);
    for (int i = 0; i < n; i++) recv_byte(i == n - 1);
    bstop();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic ack;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 sda_pull", sda_pull, 0);
    chk("R1 poll_stalled", poll_stalled, 0);
    chk("R1 prod_ready", prod_ready, 1);

    // R2/R6 write at default address (0x84)
    bstart();
    send_byte(8'h84, ack); chk("R2 0x84 ack", ack, 1);
    exp_rx.push_back(8'h5A); send_byte(8'h5A, ack); chk("R6 data ack", ack, 1);
    exp_rx.push_back(8'hC3); send_byte(8'hC3, ack); chk("R6 data ack", ack, 1);
    bstop();

    // R2 wrong address not acked
    bstart(); send_byte(8'hA0, ack); chk("R2 mismatch nack", ack, 0); bstop();

    // R4/R5 ordered read then filler
    produce(8'h11, "R4 order"); produce(8'h22, "R4 order"); produce(8'h33, "R4 order");
    expect_rd(8'hFF, "R5 filler");
    read_n(7'h42, 4, "R2");

    // R12 fill FIFO
    for (int i = 0; i < 8; i++) produce(8'h80 + 8'(i), "R4 full order");
    chk("R12 prod_ready full", prod_ready, 0);
    produce(8'hEE, "R12 dropped");
    expect_rd(8'hFF, "R12 drop check");
    read_n(7'h42, 9, "R12");

    // R7 master NACK stops popping
    produce(8'hA1, "R7 first"); produce(8'hA2, "R7 kept");
    read_n(7'h42, 1, "R7");
    expect_rd(8'hFF, "R7 filler");
    read_n(7'h42, 2, "R7");

    // R8 repeated START switches direction
    bstart();
    send_byte(8'h84, ack); chk("R8 write ack", ack, 1);
    exp_rx.push_back(8'h77); send_byte(8'h77, ack);
    bstart();
    send_byte(8'h85, ack); chk("R8 Sr read ack", ack, 1);
    expect_rd(8'hFF, "R8 read after Sr");
    recv_byte(1'b1);
    bstop();

    // R3 address change
    @(negedge clk); cfg_addr = 7'h33; cfg_addr_we = 1;
    @(negedge clk); cfg_addr_we = 0;
    bstart(); send_byte(8'h84, ack); chk("R3 old addr nack", ack, 0); bstop();
    expect_rd(8'hFF, "R3 new addr data");
    read_n(7'h33, 1, "R3");

    // R9/R10 poll watchdog
    produce(8'h5C, "R10 kept across timeout");
    chk("R9 not stalled early", poll_stalled, 0);
    repeat (TIMEOUT + 300) @(negedge clk);
    chk("R9 stalled", poll_stalled, 1);
    chk("R9 prod_ready low", prod_ready, 0);
    produce(8'hEE, "R9 dropped");
    expect_rd(8'hFF, "R9 drop check");
    read_n(7'h33, 2, "R9");
    chk("R9 cleared by read", poll_stalled, 0);
    chk("R9 prod_ready back", prod_ready, 1);

    repeat (20) @(negedge clk);
    chk("R4 all reads seen", exp_rd.size(), 0);
    chk("R6 all rx seen", exp_rx.size(), 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule